// File: doc/BRIEF.md
# Multiplexed-Bus Host Register Interface

This block sits between a host that shares one byte-wide bus for address and data and a controller's small register file and internal buffer RAM. While the address-latch strobe is high, the block samples the register select from the low address bits and samples the chip select. It keeps both once the strobe falls. The read and write strobes arrive asynchronously, so each one passes through a two-flop synchroniser and an edge detector before it has any side effect. Reads are served on ticks of an internal arbitration clock enable. Its rate is set by a two-bit operating-speed select and a slow-arbitration bit.

The buffer RAM is reached through a byte-wide data register addressed by an internal pointer. Every data-register read or write starts a recovery window five arbitration ticks long, and the pointer steps by one at its end. Reads of the pointer bytes or of the data register that arrive inside the window are held back until the step has finished, so the host never sees a stale pointer. A status register shows the window as a busy bit.

Top module: `mhb_host_if`

## Requirements
- R1: On the decode, register select is `ad_in[2:0]` and chip select is `ncs`, both sampled on every clock while `ale` is high. Values on `ad_in` after `ale` falls do not change which register an access reaches.
- R2: A read with chip select low drives `ad_oe` high, with the register contents on `ad_out`, no later than 4 arbitration periods after `nrd` falls, provided no recovery window blocks it.
- R3: `ad_oe` is low in the same cycle that `nrd` is high.
- R4: With chip select latched high, a read never drives `ad_oe` and a write changes no register.
- R5: The arbitration period in core clocks is 8, 4, 2 or 1 for `ckup_sel` 0, 1, 2 or 3, and doubles when `slow_arb` is 1.
- R6: Register 4 is the data register. A read returns the RAM byte at the pointer and a write stores `ad_in` there. Each such access moves the pointer up by one at the end of its recovery window.
- R7: Register 0 is status, with bit 0 = recovery window active and the other bits 0. A data-register write sets the busy bit on the next clock.
- R8: Reads of register 2 (pointer high bits in bits [RAM_AW-9:0]) or register 3 (pointer bits [7:0]) wait until any recovery window ends and return the stepped pointer. The window lasts at least 4 full arbitration periods.
- R9: Writing register 2 or 3 loads that part of the pointer and cancels any pending step. The pointer wraps from all ones to zero.
- R10: Registers 1, 5, 6 and 7 are byte-wide scratch registers that read back what was written.
- R11: After reset, `ad_oe` is low, the pointer is zero, status reads 0 and the scratch registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ckup_sel | input | 2 | Operating-speed select |
| slow_arb | input | 1 | Halves the arbitration tick rate when 1 |
| ale | input | 1 | Address latch strobe, sampled while high |
| ncs | input | 1 | Chip select, active low, latched with address |
| nrd | input | 1 | Read strobe, active low |
| nwr | input | 1 | Write strobe, active low |
| ad_in | input | 8 | Multiplexed address/data bus, inbound |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Bus output enable (tristate control) |

## Verification
The bench builds the block with `RAM_AW` = 10, so the high pointer byte holds two bits and the wrap from 0x3FF to zero needs only two register writes. It runs the same access sequence under four speed settings, with arbitration periods of 1, 2, 4 and 16 clocks. This checks the 4-period read deadline at the fastest rate, where the synchroniser takes most of the budget. It also brings the recovery window within reach of a status read at the slowest rate. Pointer reads issued straight after data accesses check both the stall and the stepped value.

// File: rtl/mhb_pkg.sv
package mhb_pkg;

    localparam int DIV_W = 4;

    typedef enum logic [2:0] {
        REG_STATUS = 3'd0,
        REG_SCR_A  = 3'd1,
        REG_PTR_HI = 3'd2,
        REG_PTR_LO = 3'd3,
        REG_DATA   = 3'd4,
        REG_SCR_B  = 3'd5,
        REG_SCR_C  = 3'd6,
        REG_SCR_D  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     cs_n;
    } bus_latch_t;

    // Low-bit mask of the free-running divider for the operating clock.
    function automatic logic [DIV_W-1:0] op_mask_f(input logic [1:0] ck);
        case (ck)
            2'd0:    return DIV_W'(7);
            2'd1:    return DIV_W'(3);
            2'd2:    return DIV_W'(1);
            default: return DIV_W'(0);
        endcase
    endfunction

    function automatic logic is_ptr_f(input reg_sel_e s);
        return (s == REG_PTR_HI) || (s == REG_PTR_LO);
    endfunction

    function automatic reg_sel_e scr_sel_f(input int idx);
        case (idx)
            0:       return REG_SCR_A;
            1:       return REG_SCR_B;
            2:       return REG_SCR_C;
            default: return REG_SCR_D;
        endcase
    endfunction

endpackage

// File: rtl/mhb_arb_tick.sv
module mhb_arb_tick
    import mhb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ckup_sel,
    input  logic       slow_arb,
    output logic       arb_tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] op_m;
    logic [DIV_W-1:0] arb_m;

    assign op_m     = op_mask_f(ckup_sel);
    assign arb_m    = slow_arb ? {op_m[DIV_W-2:0], 1'b1} : op_m;
    assign arb_tick = (div_q & arb_m) == arb_m;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // Checker: spacing between ticks under an unchanged configuration.
    logic [DIV_W:0] gap_q;
    logic [2:0]     cfg_q;
    logic           clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            cfg_q   <= '0;
            clean_q <= 1'b0;
        end else begin
            cfg_q <= {ckup_sel, slow_arb};
            gap_q <= arb_tick ? '0 : gap_q + 1'b1;
            if (cfg_q != {ckup_sel, slow_arb}) clean_q <= 1'b0;
            else if (arb_tick)                 clean_q <= 1'b1;
        end
    end

    assert_arb_period_R5: assert property (@(posedge clk) disable iff (rst)
        (arb_tick && clean_q && cfg_q == {ckup_sel, slow_arb})
            |-> gap_q == {1'b0, arb_m});

endmodule

// File: rtl/mhb_strobe_sync.sv
module mhb_strobe_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    for (genvar gi = 0; gi < N; gi++) begin : g_line
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
                s3_q <= 1'b1;
            end else begin
                s1_q <= raw_n[gi];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign lvl_n[gi] = s2_q;
        assign fall[gi]  = s3_q & ~s2_q;
        assign rise[gi]  = ~s3_q & s2_q;
    end

endmodule

// File: rtl/mhb_ptr_guard.sv
module mhb_ptr_guard #(
    parameter int RAM_AW   = 11,
    parameter int BUSY_WIN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arb_tick,
    input  logic              start,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [7:0]        wdat,
    output logic [RAM_AW-1:0] ptr,
    output logic              busy
);

    localparam int HI_W = RAM_AW - 8;
    localparam int CW   = $clog2(BUSY_WIN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            cnt_q <= '0;
        end else if (wr_hi) begin
            ptr[RAM_AW-1:8] <= wdat[HI_W-1:0];
            cnt_q           <= '0;
        end else if (wr_lo) begin
            ptr[7:0] <= wdat;
            cnt_q    <= '0;
        end else if (start) begin
            cnt_q <= CW'(BUSY_WIN);
        end else if (arb_tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) ptr <= ptr + 1'b1;
        end
    end

    assign busy = cnt_q != '0;

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(wr_hi || wr_lo))
            |-> ptr == RAM_AW'($past(ptr) + 1'b1));

endmodule

// File: rtl/mhb_host_if.sv
module mhb_host_if
    import mhb_pkg::*;
#(
    parameter int RAM_AW   = 11,
    parameter int BUSY_WIN = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ckup_sel,
    input  logic       slow_arb,
    input  logic       ale,
    input  logic       ncs,
    input  logic       nrd,
    input  logic       nwr,
    input  logic [7:0] ad_in,
    output logic [7:0] ad_out,
    output logic       ad_oe
);

    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int HI_W      = RAM_AW - 8;
    localparam int N_SCR     = 4;

    // Address and chip-select latch: tracks while ALE high, holds after.
    bus_latch_t lat_q;
    always_ff @(posedge clk) begin
        if (rst)      lat_q <= '{sel: REG_STATUS, cs_n: 1'b1};
        else if (ale) lat_q <= '{sel: reg_sel_e'(ad_in[2:0]), cs_n: ncs};
    end

    // Strobe synchronisation (bit 0 read, bit 1 write).
    logic [1:0] stb_lvl, stb_fall, stb_rise;
    mhb_strobe_sync #(.N(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw_n({nwr, nrd}),
        .lvl_n(stb_lvl),
        .fall (stb_fall),
        .rise (stb_rise)
    );

    logic rd_fall, rd_rise, wr_rise;
    assign rd_fall = stb_fall[0];
    assign rd_rise = stb_rise[0];
    assign wr_rise = stb_rise[1];

    logic arb_tick;
    mhb_arb_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .ckup_sel(ckup_sel),
        .slow_arb(slow_arb),
        .arb_tick(arb_tick)
    );

    // Write data sampled while the synchronised write strobe is low.
    logic [7:0] wdat_q;
    always_ff @(posedge clk) begin
        if (rst)             wdat_q <= '0;
        else if (!stb_lvl[1]) wdat_q <= ad_in;
    end

    logic wr_commit, wr_data;
    assign wr_commit = wr_rise && !lat_q.cs_n;
    assign wr_data   = wr_commit && lat_q.sel == REG_DATA;

    // Read service.
    logic rd_pend_q, rd_valid_q, stall, serve, rd_req;
    logic [7:0] dout_q, rd_mux;
    logic [RAM_AW-1:0] ptr;
    logic busy;

    assign rd_req = (rd_fall || rd_pend_q) && !lat_q.cs_n;
    assign stall  = busy && (is_ptr_f(lat_q.sel) || lat_q.sel == REG_DATA);
    assign serve  = rd_req && arb_tick && !stall && !rd_rise;

    mhb_ptr_guard #(.RAM_AW(RAM_AW), .BUSY_WIN(BUSY_WIN)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .arb_tick(arb_tick),
        .start   ((serve && lat_q.sel == REG_DATA) || wr_data),
        .wr_hi   (wr_commit && lat_q.sel == REG_PTR_HI),
        .wr_lo   (wr_commit && lat_q.sel == REG_PTR_LO),
        .wdat    (wdat_q),
        .ptr     (ptr),
        .busy    (busy)
    );

    // Scratch registers.
    logic [7:0] scr_q [N_SCR];
    for (genvar gi = 0; gi < N_SCR; gi++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst)
                scr_q[gi] <= '0;
            else if (wr_commit && lat_q.sel == scr_sel_f(gi))
                scr_q[gi] <= wdat_q;
        end
    end

    // Buffer RAM.
    logic [7:0] ram [RAM_DEPTH];
    always_ff @(posedge clk) begin
        if (wr_data) ram[ptr] <= wdat_q;
    end

    always_comb begin
        case (lat_q.sel)
            REG_STATUS: rd_mux = {7'b0, busy};
            REG_PTR_HI: rd_mux = {{(8-HI_W){1'b0}}, ptr[RAM_AW-1:8]};
            REG_PTR_LO: rd_mux = ptr[7:0];
            REG_DATA:   rd_mux = ram[ptr];
            REG_SCR_A:  rd_mux = scr_q[0];
            REG_SCR_B:  rd_mux = scr_q[1];
            REG_SCR_C:  rd_mux = scr_q[2];
            default:    rd_mux = scr_q[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q  <= 1'b0;
            rd_valid_q <= 1'b0;
            dout_q     <= '0;
        end else if (rd_rise) begin
            rd_pend_q  <= 1'b0;
            rd_valid_q <= 1'b0;
        end else if (serve) begin
            rd_pend_q  <= 1'b0;
            rd_valid_q <= 1'b1;
            dout_q     <= rd_mux;
        end else if (rd_fall) begin
            rd_pend_q  <= !lat_q.cs_n;
            rd_valid_q <= 1'b0;
        end
    end

    assign ad_out = dout_q;
    assign ad_oe  = rd_valid_q && !nrd;

    assert_ptr_rd_guard_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_valid_q) && is_ptr_f(lat_q.sel)) |-> !$past(busy));

    assert_data_rd_busy_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_valid_q) && lat_q.sel == REG_DATA) |-> busy);

    assert_wr_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_rise && !lat_q.cs_n && lat_q.sel == REG_DATA) |=> busy);

    assert_cs_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid_q) |-> !lat_q.cs_n);

endmodule

// File: tb/sim_mhb_host_if.sv
module sim_mhb_host_if;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ckup_sel = 2'd3;
    logic       slow_arb = 1'b0;
    logic       ale = 1'b0, ncs = 1'b1, nrd = 1'b1, nwr = 1'b1;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;

    always #4 clk = ~clk;

    mhb_host_if #(.RAM_AW(10), .BUSY_WIN(5)) u0 (
        .clk(clk), .rst(rst), .ckup_sel(ckup_sel), .slow_arb(slow_arb),
        .ale(ale), .ncs(ncs), .nrd(nrd), .nwr(nwr),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, per = 1, last_oe = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       oe_prev = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compares each new bus drive against the scoreboard.
    always @(negedge clk) begin
        if (ad_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 drive without pending read", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(ad_out === e, t, ad_out, e);
            end
        end
        oe_prev = ad_oe;
    end

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input logic cs_n = 1'b0);
        @(negedge clk); ad_in = {5'b0, a}; ale = 1'b1; ncs = cs_n;
        @(negedge clk); ale = 1'b0; ad_in = d; nwr = 1'b0;
        repeat (3) @(negedge clk);
        nwr = 1'b1;
        repeat (3) @(negedge clk);
        ncs = 1'b1;
    endtask

    // Read: R1 garbage on AD after ALE falls; R2 latency; R3 release.
    task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string tag,
                          input bit chk_lat);
        int lat = 0;
        @(negedge clk); ad_in = {5'b0, a}; ale = 1'b1; ncs = 1'b0;
        @(negedge clk); ale = 1'b0; ad_in = {5'b10101, ~a}; nrd = 1'b0;
        exp_q.push_back(e); tag_q.push_back(tag);
        while (!ad_oe && lat < 3000) begin
            @(negedge clk); lat++;
        end
        last_oe = cyc;
        if (chk_lat) chk(lat <= 4 * per, "R2 R5 read latency", lat, 4 * per);
        repeat (2) @(negedge clk);
        nrd = 1'b1;
        #1 chk(ad_oe == 1'b0, "R3 release on nrd high", ad_oe, 0);
        @(negedge clk); ncs = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle();
        repeat (6 * per + 8) @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        chk(ad_oe == 1'b0, "R11 reset oe", ad_oe, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        bus_rd(3'd0, 8'h00, "R11 status after reset", 1'b1);
        bus_rd(3'd2, 8'h00, "R11 ptr hi after reset", 1'b1);
        bus_rd(3'd3, 8'h00, "R11 ptr lo after reset", 1'b1);
        bus_rd(3'd6, 8'h00, "R11 scratch after reset", 1'b1);

        bus_wr(3'd1, 8'h3C); bus_wr(3'd5, 8'h5A);
        bus_wr(3'd6, 8'hA5); bus_wr(3'd7, 8'hC3);
        bus_rd(3'd1, 8'h3C, "R10 R1 scratch 1", 1'b1);
        bus_rd(3'd5, 8'h5A, "R10 scratch 5", 1'b1);
        bus_rd(3'd6, 8'hA5, "R10 scratch 6", 1'b1);
        bus_rd(3'd7, 8'hC3, "R10 scratch 7", 1'b1);

        // R4: chip select high
        bus_wr(3'd1, 8'hFF, 1'b1);
        begin
            bit seen = 1'b0;
            @(negedge clk); ad_in = 8'd1; ale = 1'b1; ncs = 1'b1;
            @(negedge clk); ale = 1'b0; nrd = 1'b0;
            repeat (30) begin @(negedge clk); if (ad_oe) seen = 1'b1; end
            chk(!seen, "R4 no drive when deselected", seen, 0);
            nrd = 1'b1;
            repeat (4) @(negedge clk);
        end
        bus_rd(3'd1, 8'h3C, "R4 write ignored when deselected", 1'b1);

        for (int c = 0; c < 4; c++) begin
            automatic logic [1:0] ck = (c == 0) ? 2'd3 : (c == 1) ? 2'd3 : (c == 2) ? 2'd1 : 2'd0;
            automatic logic       sl = (c == 1) || (c == 3);
            automatic logic [7:0] base = 8'h40 + 8'(16 * c);
            int f_cyc;
            @(negedge clk); ckup_sel = ck; slow_arb = sl;
            per = (8 >> ck) * (sl ? 2 : 1);
            idle();
            bus_wr(3'd2, 8'h01); bus_wr(3'd3, base);
            bus_wr(3'd4, 8'h90 + 8'(c));
            bus_rd(3'd3, base + 8'd1, "R8 ptr after data write", 1'b0);
            bus_rd(3'd2, 8'h01, "R8 ptr hi", 1'b1);
            idle();
            bus_wr(3'd4, 8'h0F ^ 8'(c));
            idle();
            bus_wr(3'd3, base);
            f_cyc = cyc;
            bus_rd(3'd4, 8'h90 + 8'(c), "R6 data read", 1'b1);
            bus_rd(3'd3, base + 8'd1, "R8 ptr after data read", 1'b0);
            chk(last_oe - f_cyc >= 4 * per + 2, "R8 R5 window length", last_oe - f_cyc, 4 * per + 2);
            idle();
            bus_rd(3'd4, 8'h0F ^ 8'(c), "R6 data read next", 1'b1);
            idle();
            bus_rd(3'd3, base + 8'd2, "R6 ptr stepped", 1'b1);
            if (per >= 8) begin
                bus_wr(3'd4, 8'h33);
                bus_rd(3'd0, 8'h01, "R7 busy visible", 1'b1);
                idle();
                bus_rd(3'd0, 8'h00, "R7 busy cleared", 1'b1);
            end
        end

        // R9: wrap from all ones
        bus_wr(3'd2, 8'h03); bus_wr(3'd3, 8'hFF);
        bus_wr(3'd4, 8'hEE);
        idle();
        bus_rd(3'd2, 8'h00, "R9 wrap hi", 1'b1);
        bus_rd(3'd3, 8'h00, "R9 wrap lo", 1'b1);
        bus_wr(3'd2, 8'h03); bus_wr(3'd3, 8'hFF);
        bus_rd(3'd4, 8'hEE, "R9 R6 data at top", 1'b1);
        idle();
        chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule